// File: doc/BRIEF.md
# Auto-Reload Interval Timer

This block is a 32-bit interval timer that sits on a simple word-addressed register bus. Its counter counts upward, one step per pulse of a slow timebase enable (nominally 32768 Hz). When the counter passes all ones, it raises an overflow flag. It then either reloads from a programmed value or stops at zero. Software sets a period of N ticks by writing the two's-complement negative of N into the load register. Software may also rewrite the live count at any moment to stretch or shorten the current period.

An interrupt line is asserted while any latched status flag has its enable bit set. Flags are cleared by writing one to them. A software reset request clears every register. A done bit reads 0 while that reset is in progress and 1 once it has finished, and software polls it.

Top module: `auto_reload_timer`

## Requirements
- R1: After the reset input, the revision register (byte offset 0x00) reads the REV_ID parameter, the status register (0x14) reads 1, and the counter (0x28), load (0x2C), control (0x24), flag (0x18) and enable (0x1C) registers all read 0.
- R2: The counter increases by one on each cycle in which tick_i is high and control bit 0 (run) is set. It holds its value when tick_i is low or run is clear.
- R3: When a tick arrives with the counter at 0xFFFFFFFF, control bit 1 (reload) set and run set, the counter takes the load register value, and flag bit 1 (overflow) is set.
- R4: With reload clear, a tick at 0xFFFFFFFF wraps the counter to 0, sets overflow, and clears run, so later ticks leave the counter at 0.
- R5: A write to the flag register clears exactly those flag bits (bit 0 match, bit 1 overflow, bit 2 capture) that are written as 1. Bits written as 0 keep their value.
- R6: irq_o is high exactly when some flag bit and the enable bit at the same position are both 1.
- R7: A write to the counter in the same cycle as a qualifying tick sets the counter to the written value, and the tick has no effect.
- R8: The control register stores only bits 0, 1, 10 and 11. Writing 0xFFFFFFFF reads back 0x00000C03.
- R9: Writing 1 to config bit 1 (offset 0x10) starts a soft reset lasting RST_CYCLES cycles. During that time the status register reads 0, config bit 1 reads 1, and bus writes are ignored. Afterwards every register reads its R1 value and the status register reads 1.
- R10: Config bit 0 (idle enable) is stored and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase enable, one clock wide |
| addr_i | input | ADDR_W | Byte address, word aligned |
| we_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data (combinational from addr_i) |
| irq_o | output | 1 | Interrupt request |

## Verification
Register reads are combinational, so a value written or updated at one rising edge can be read back in the low phase of the following cycle. The counter, the flags and the run bit all change at the same edge that samples a tick or a write, and irq_o follows the flags in that same cycle. The driver issues each read at a falling edge, after the edge that caused the change. It pushes the expected value into a queue, and the monitor compares it a short delay later, while the inputs are steady. The soft-reset window is probed inside its RST_CYCLES span and again after a margin past it.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_REV  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_FLAG = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_LOAD = 6'h2C;

  localparam int unsigned FLAG_W = 3;
  localparam int unsigned FLAG_OVF = 1;

  typedef struct packed {
    logic trg_match;
    logic trg_ovf;
    logic reload;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/timer_rst_seq.sv
module timer_rst_seq #(
  parameter int unsigned RST_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (req_i)       cnt_q <= CW'(RST_CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         reload_i,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         step;

  assign step  = tick_i && run_i && !wr_i && !clr_i;
  assign ovf_o = step && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;  // write beats tick
    else if (ovf_o)  cnt_q <= reload_i ? load_i : '0;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cfg_wr_i,
  input  logic              flag_wr_i,
  input  logic              ien_wr_i,
  input  logic              ctrl_wr_i,
  input  logic              load_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ovf_i,
  output logic              idle_o,
  output logic [FLAG_W-1:0] flag_o,
  output logic [FLAG_W-1:0] ien_o,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] load_o
);
  logic [FLAG_W-1:0] flag_set;

  always_comb begin
    flag_set = '0;
    flag_set[FLAG_OVF] = ovf_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_o <= 1'b0;
      flag_o <= '0;
      ien_o  <= '0;
      ctrl_o <= '0;
      load_o <= '0;
    end else if (clr_i) begin
      idle_o <= 1'b0;
      flag_o <= '0;
      ien_o  <= '0;
      ctrl_o <= '0;
      load_o <= '0;
    end else begin
      if (cfg_wr_i)  idle_o <= wdata_i[0];
      if (ien_wr_i)  ien_o  <= wdata_i[FLAG_W-1:0];
      if (load_wr_i) load_o <= wdata_i;
      // a new event wins over a same-cycle clear
      flag_o <= (flag_o & ~(flag_wr_i ? wdata_i[FLAG_W-1:0] : '0)) | flag_set;
      if (ctrl_wr_i)
        ctrl_o <= '{trg_match: wdata_i[11], trg_ovf: wdata_i[10],
                    reload: wdata_i[1], run: wdata_i[0]};
      else if (ovf_i && !ctrl_o.reload)
        ctrl_o.run <= 1'b0;  // one-shot stop
    end
  end
endmodule

// File: rtl/auto_reload_timer.sv
module auto_reload_timer
  import timer_pkg::*;
#(
  parameter logic [DATA_W-1:0] REV_ID     = 32'h0000_0031,
  parameter int unsigned       RST_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              busy, wr_ok, srst_req, ovf, idle;
  logic [FLAG_W-1:0] flag_q, ien_q;
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] load_q, cnt_q;

  assign wr_ok    = we_i && !busy;
  assign srst_req = wr_ok && (addr_i == OFS_CFG) && wdata_i[1];

  timer_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i, .rst_ni, .req_i(srst_req), .busy_o(busy)
  );

  timer_regs u_regs (
    .clk_i, .rst_ni,
    .clr_i    (busy),
    .cfg_wr_i (wr_ok && addr_i == OFS_CFG && !wdata_i[1]),
    .flag_wr_i(wr_ok && addr_i == OFS_FLAG),
    .ien_wr_i (wr_ok && addr_i == OFS_IEN),
    .ctrl_wr_i(wr_ok && addr_i == OFS_CTRL),
    .load_wr_i(wr_ok && addr_i == OFS_LOAD),
    .wdata_i,
    .ovf_i    (ovf),
    .idle_o   (idle),
    .flag_o   (flag_q),
    .ien_o    (ien_q),
    .ctrl_o   (ctrl_q),
    .load_o   (load_q)
  );

  timer_counter #(.W(DATA_W)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i   (busy),
    .wr_i    (wr_ok && addr_i == OFS_CNT),
    .wdata_i,
    .tick_i,
    .run_i   (ctrl_q.run),
    .reload_i(ctrl_q.reload),
    .load_i  (load_q),
    .cnt_o   (cnt_q),
    .ovf_o   (ovf)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_REV:  rdata_o = REV_ID;
      OFS_CFG:  rdata_o[1:0] = {busy, idle};
      OFS_STAT: rdata_o[0] = !busy;
      OFS_FLAG: rdata_o[FLAG_W-1:0] = flag_q;
      OFS_IEN:  rdata_o[FLAG_W-1:0] = ien_q;
      OFS_CTRL: begin
        rdata_o[11:10] = {ctrl_q.trg_match, ctrl_q.trg_ovf};
        rdata_o[1:0]   = {ctrl_q.reload, ctrl_q.run};
      end
      OFS_CNT:  rdata_o = cnt_q;
      OFS_LOAD: rdata_o = load_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = |(flag_q & ien_q);
endmodule

// File: rtl/auto_reload_timer_chk.sv
module auto_reload_timer_chk
  import timer_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic              busy,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] load_q,
  input logic [FLAG_W-1:0] flag_q,
  input ctrl_t             ctrl_q
);
  logic cnt_wr, ctrl_wr, go;
  assign cnt_wr  = we_i && !busy && addr_i == OFS_CNT;
  assign ctrl_wr = we_i && !busy && addr_i == OFS_CTRL;
  assign go      = !busy && !cnt_wr && tick_i && ctrl_q.run;

  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && !cnt_wr && !(tick_i && ctrl_q.run) |=> $stable(cnt_q)); // R2
  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && !(&cnt_q) |=> cnt_q == $past(cnt_q) + 1); // R2
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && (&cnt_q) && ctrl_q.reload |=> cnt_q == $past(load_q) && flag_q[FLAG_OVF]); // R3
  AST_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && (&cnt_q) && !ctrl_q.reload && !ctrl_wr |=> cnt_q == '0 && !ctrl_q.run); // R4
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> cnt_q == $past(wdata_i)); // R7
  AST_SOFT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> cnt_q == '0 && flag_q == '0 && !ctrl_q.run); // R9
  AST_STAT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && addr_i == OFS_STAT |-> rdata_o[0] == 1'b0); // R9
endmodule

bind auto_reload_timer auto_reload_timer_chk u_chk (
  .clk_i, .rst_ni, .tick_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o,
  .busy, .cnt_q, .load_q, .flag_q, .ctrl_q
);

// File: tb/auto_reload_timer_tb.sv
module auto_reload_timer_tb;
  import timer_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] REV = 32'h0000_0031;

  logic              clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0, rdata_o;
  logic              irq_o;

  auto_reload_timer #(.REV_ID(REV), .RST_CYCLES(8)) u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  event  rd_ev;
  int    n_run = 0, n_fail = 0;

  // monitor: compares after inputs settle in the low phase
  initial forever begin
    item_t it;
    @(rd_ev);
    #1;
    it = q.pop_front();
    n_run++;
    if (it.is_irq) begin
      if (irq_o !== it.exp[0]) begin
        n_fail++;
        $display("FAIL %s irq actual=%0b expected=%0b", it.tag, irq_o, it.exp[0]);
      end
    end else if (rdata_o !== it.exp) begin
      n_fail++;
      $display("FAIL %s rdata actual=%h expected=%h", it.tag, rdata_o, it.exp);
    end
  end

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
    item_t it;
    @(negedge clk_i);
    addr_i = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = t;
    q.push_back(it);
    -> rd_ev;
  endtask

  task automatic chk_irq(input logic e, input string t);
    item_t it;
    @(negedge clk_i);
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = t;
    q.push_back(it);
    -> rd_ev;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input bit tk = 1'b0);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1; tick_i = tk;
    @(negedge clk_i);
    we_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    rd(OFS_REV, REV, "R1");
    rd(OFS_STAT, 32'h1, "R1");
    rd(OFS_CNT, 32'h0, "R1");
    rd(OFS_LOAD, 32'h0, "R1");
    rd(OFS_CTRL, 32'h0, "R1");
    rd(OFS_FLAG, 32'h0, "R1");
    rd(OFS_IEN, 32'h0, "R1");
    chk_irq(1'b0, "R6");
    // period of 3 ticks
    wr(OFS_LOAD, 32'hFFFF_FFFD);
    wr(OFS_CNT, 32'hFFFF_FFFD);
    wr(OFS_IEN, 32'h2);
    wr(OFS_CTRL, 32'h3);
    tick();
    rd(OFS_CNT, 32'hFFFF_FFFE, "R2");
    tick();
    rd(OFS_CNT, 32'hFFFF_FFFF, "R2");
    chk_irq(1'b0, "R6");
    tick();
    rd(OFS_CNT, 32'hFFFF_FFFD, "R3");
    rd(OFS_FLAG, 32'h2, "R3");
    chk_irq(1'b1, "R6");
    repeat (3) tick();
    rd(OFS_CNT, 32'hFFFF_FFFD, "R3");
    // W1C
    wr(OFS_FLAG, 32'h5);
    rd(OFS_FLAG, 32'h2, "R5");
    wr(OFS_FLAG, 32'h2);
    rd(OFS_FLAG, 32'h0, "R5");
    chk_irq(1'b0, "R6");
    // stopped
    wr(OFS_CTRL, 32'h0);
    tick();
    rd(OFS_CNT, 32'hFFFF_FFFD, "R2");
    // write vs tick same cycle
    wr(OFS_CTRL, 32'h3);
    wr(OFS_CNT, 32'h5, 1'b1);
    rd(OFS_CNT, 32'h5, "R7");
    // one shot
    wr(OFS_CTRL, 32'h1);
    wr(OFS_CNT, 32'hFFFF_FFFF);
    tick();
    rd(OFS_CNT, 32'h0, "R4");
    rd(OFS_CTRL, 32'h0, "R4");
    rd(OFS_FLAG, 32'h2, "R4");
    tick();
    rd(OFS_CNT, 32'h0, "R4");
    wr(OFS_IEN, 32'h0);
    chk_irq(1'b0, "R6");
    wr(OFS_IEN, 32'h7);
    chk_irq(1'b1, "R6");
    // control mask
    wr(OFS_CTRL, 32'hFFFF_FFFF);
    rd(OFS_CTRL, 32'h0000_0C03, "R8");
    // idle bit
    wr(OFS_CFG, 32'h1);
    rd(OFS_CFG, 32'h1, "R10");
    wr(OFS_CFG, 32'h0);
    rd(OFS_CFG, 32'h0, "R10");
    // soft reset
    wr(OFS_LOAD, 32'h1234);
    wr(OFS_CFG, 32'h3);
    rd(OFS_STAT, 32'h0, "R9");
    rd(OFS_CFG, 32'h2, "R9");
    wr(OFS_CNT, 32'h7);
    repeat (12) @(negedge clk_i);
    rd(OFS_STAT, 32'h1, "R9");
    rd(OFS_CFG, 32'h0, "R9");
    rd(OFS_CNT, 32'h0, "R9");
    rd(OFS_LOAD, 32'h0, "R9");
    rd(OFS_CTRL, 32'h0, "R9");
    rd(OFS_FLAG, 32'h0, "R9");
    rd(OFS_IEN, 32'h0, "R9");
    chk_irq(1'b0, "R9");
    finish_run();
  end
endmodule